// File: doc/BRIEF.md
# Intrawave Collision Lane Sequencer

This block splits one wave of fragment work into ordered sub-groups. A wave has 32 or 64 lanes, grouped four to a quad. A collision word gives one bit per quad. A set bit marks a quad that opens a new overlap layer: that quad and the quads after it must wait until every lower lane has run its ordered code. The sequencer turns the word into a series of contiguous lane masks, from lane 0 upward, and issues them one at a time.

A wave is loaded with its collision word, its size and its execution mask. The block then presents one lane mask with a valid flag. It keeps that mask until the consumer signals that the layer has finished, and then moves on to the next layer. Every mask is limited to the lanes that are active in the wave. A layer with no active lanes is skipped without any handshake. The final mask carries a last flag. When that mask is acknowledged, the block goes back to idle and can accept a new load.

Top module: `quad_layer_sequencer`

## Requirements
- R1: After reset, lane_valid and lane_last are low and the block is idle, so the first load is accepted.
- R2: Quad q covers lanes 4q to 4q+3. Layers are contiguous lane ranges issued in ascending order starting at lane 0. Example: a 64-lane wave with collision bits 2, 7, 8 and 9 set and all lanes active gives lanes 7:0, 27:8, 31:28, 35:32 and 63:36, in that order.
- R3: Collision bit q with q > 0 starts a new layer at lane 4q. Bit 0 has no effect on the result.
- R4: With wide_wave = 0 (32 lanes), only collision bits 7:0 and exec_mask bits 31:0 are used, and lane_mask[63:32] stays 0. With wide_wave = 1 (64 lanes), only collision bits 15:0 are used. In both cases, collision bits 31:16 are ignored.
- R5: Each issued lane_mask is the layer's lane range ANDed with the loaded execution mask.
- R6: A layer with no active lanes is never presented. lane_valid is only high with a non-zero lane_mask.
- R7: While lane_valid is high and layer_done is low, lane_mask and lane_last hold their values. The next layer is issued only after a clock edge with both lane_valid and layer_done high.
- R8: lane_last is high exactly with the final non-empty layer. After that layer is acknowledged, lane_valid is low in the next cycle.
- R9: A load_valid pulse while a wave is being sequenced is ignored.
- R10: A load whose active lanes (within the wave size) are all zero issues no layer and leaves the block idle.
- R11: layer_done while lane_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Load a new wave (taken only when idle) |
| load_collision | input | 32 | Per-quad layer-start word |
| load_wide | input | 1 | 1 = 64-lane wave, 0 = 32-lane wave |
| load_exec | input | 64 | Execution mask of the wave |
| lane_valid | output | 1 | A layer mask is presented |
| lane_mask | output | 64 | Active lanes of the current layer |
| lane_last | output | 1 | The presented layer is the final one |
| layer_done | input | 1 | The consumer finished the presented layer |

## Verification
All outputs come combinationally from registered state. A layer therefore appears on the clock edge that accepts the load or the previous acknowledge, plus one extra edge for each skipped empty layer. The bench drives inputs and samples outputs on falling edges. For each layer it waits a bounded number of cycles for lane_valid, compares mask and last flag with a layer list it builds itself from the requirements, and holds the acknowledge off in some cases to check that the values stay stable. After the final acknowledge, it checks on the next falling edge that lane_valid is low.

// File: rtl/qls_pkg.sv
package qls_pkg;
    localparam int QLS_LANES_PER_QUAD = 4;
    localparam int QLS_MAX_LANES      = 64;
    localparam int QLS_WORD_W         = 32;
endpackage

// File: rtl/qls_boundary_find.sv
module qls_boundary_find #(
    parameter int QUADS  = 16,
    parameter int QIDX_W = 5
) (
    input  logic [QUADS-1:0]  coll,
    input  logic [QIDX_W-1:0] start,
    input  logic [QIDX_W-1:0] limit,
    output logic [QIDX_W-1:0] bound
);
    // Lowest set collision bit strictly above start and below limit; else limit.
    always_comb begin
        bound = limit;
        for (int i = QUADS - 1; i >= 0; i--) begin
            if (coll[i] && (QIDX_W'(i) > start) && (QIDX_W'(i) < limit)) begin
                bound = QIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/qls_quad_expand.sv
module qls_quad_expand
    import qls_pkg::*;
#(
    parameter int QUADS  = 16,
    parameter int QIDX_W = 5,
    localparam int LANES = QUADS * QLS_LANES_PER_QUAD
) (
    input  logic [QIDX_W-1:0] lo,
    input  logic [QIDX_W-1:0] hi,
    output logic [LANES-1:0]  lanes
);
    // Quad q (lo <= q < hi) enables lanes 4q..4q+3.
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        assign lanes[q*QLS_LANES_PER_QUAD +: QLS_LANES_PER_QUAD] =
            {QLS_LANES_PER_QUAD{(QIDX_W'(q) >= lo) && (QIDX_W'(q) < hi)}};
    end
endmodule

// File: rtl/quad_layer_sequencer.sv
module quad_layer_sequencer
    import qls_pkg::*;
#(
    parameter int LANES  = QLS_MAX_LANES,
    parameter int WORD_W = QLS_WORD_W,
    localparam int QUADS  = LANES / QLS_LANES_PER_QUAD,
    localparam int QIDX_W = $clog2(QUADS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] load_collision,
    input  logic              load_wide,
    input  logic [LANES-1:0]  load_exec,
    output logic              lane_valid,
    output logic [LANES-1:0]  lane_mask,
    output logic              lane_last,
    input  logic              layer_done
);
    typedef struct packed {
        logic              run;
        logic              wide;
        logic [QIDX_W-1:0] start;
        logic [QUADS-1:0]  coll;
        logic [LANES-1:0]  exec;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [QIDX_W-1:0] limit_q, limit_in, bound;
    logic [LANES-1:0]  span_lanes, rest_lanes, layer_lanes, rest_active;
    logic [QUADS-1:0]  coll_in;
    logic [LANES-1:0]  exec_in;

    assign limit_q  = st_q.wide ? QIDX_W'(QUADS) : QIDX_W'(QUADS / 2);
    assign limit_in = load_wide ? QIDX_W'(QUADS) : QIDX_W'(QUADS / 2);

    qls_boundary_find #(.QUADS(QUADS), .QIDX_W(QIDX_W)) u_find (
        .coll  (st_q.coll),
        .start (st_q.start),
        .limit (limit_q),
        .bound (bound)
    );

    qls_quad_expand #(.QUADS(QUADS), .QIDX_W(QIDX_W)) u_span (
        .lo    (st_q.start),
        .hi    (bound),
        .lanes (span_lanes)
    );

    qls_quad_expand #(.QUADS(QUADS), .QIDX_W(QIDX_W)) u_rest (
        .lo    (bound),
        .hi    (limit_q),
        .lanes (rest_lanes)
    );

    assign layer_lanes = span_lanes & st_q.exec;
    assign rest_active = rest_lanes & st_q.exec;

    assign lane_valid = st_q.run && (layer_lanes != '0);
    assign lane_mask  = lane_valid ? layer_lanes : '0;
    assign lane_last  = lane_valid && (rest_active == '0);

    // Trim incoming words to the wave size.
    always_comb begin
        coll_in = '0;
        exec_in = '0;
        for (int q = 0; q < QUADS; q++) begin
            if (QIDX_W'(q) < limit_in) begin
                coll_in[q] = load_collision[q];
                exec_in[q*QLS_LANES_PER_QUAD +: QLS_LANES_PER_QUAD] =
                    load_exec[q*QLS_LANES_PER_QUAD +: QLS_LANES_PER_QUAD];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (load_valid) begin
                st_d.run   = 1'b1;
                st_d.wide  = load_wide;
                st_d.start = '0;
                st_d.coll  = coll_in;
                st_d.exec  = exec_in;
            end
        end else if ((layer_lanes == '0) || layer_done) begin
            if (rest_active == '0) begin
                st_d.run = 1'b0;
            end else begin
                st_d.start = bound;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Assertions
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid && !layer_done |=> lane_valid && $stable(lane_mask) && $stable(lane_last));

    assert_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid |-> lane_mask != '0);

    assert_exec_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid |-> (lane_mask & ~st_q.exec) == '0);

    assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid && !st_q.wide |-> lane_mask[LANES-1:LANES/2] == '0);

    assert_final_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid && lane_last && layer_done |=> !lane_valid);

    assert_load_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && load_valid |=> $stable(st_q.exec));
endmodule

// File: tb/sim_quad_layer_sequencer.sv
module sim_quad_layer_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [31:0] load_collision = '0;
    logic        load_wide = 1'b0;
    logic [63:0] load_exec = '0;
    logic        layer_done = 1'b0;
    logic        lane_valid;
    logic [63:0] lane_mask;
    logic        lane_last;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [63:0] exp_m [0:16];
    int exp_n;

    always #5 clk = ~clk;

    quad_layer_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid),
        .load_collision(load_collision), .load_wide(load_wide),
        .load_exec(load_exec), .lane_valid(lane_valid),
        .lane_mask(lane_mask), .lane_last(lane_last),
        .layer_done(layer_done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Reference layer list built from the requirements.
    task automatic build(input logic [31:0] coll, input logic wide, input logic [63:0] ex);
        int nq = wide ? 16 : 8;
        int st = 0;
        exp_n = 0;
        for (int q = 1; q <= nq; q++) begin
            if (q == nq || coll[q]) begin
                logic [63:0] m = '0;
                for (int l = 4 * st; l < 4 * q; l++) m[l] = ex[l];
                if (m != '0) begin
                    exp_m[exp_n] = m;
                    exp_n++;
                end
                st = q;
            end
        end
    endtask

    task automatic do_load(input logic [31:0] coll, input logic wide, input logic [63:0] ex);
        @(negedge clk);
        load_valid = 1'b1; load_collision = coll; load_wide = wide; load_exec = ex;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    // One scenario: load, walk every layer, check the end.
    task automatic run_case(input string req, input logic [31:0] coll, input logic wide,
                            input logic [63:0] ex, input int hold, input logic poke);
        build(coll, wide, ex);
        do_load(coll, wide, ex);
        for (int k = 0; k < exp_n; k++) begin
            for (int w = 0; w < 20 && !lane_valid; w++) @(negedge clk);
            check({req, " mask"}, lane_mask, exp_m[k]);
            check({req, " last R8"}, 64'(lane_last), 64'(k == exp_n - 1));
            if (poke) begin
                load_valid = 1'b1; load_collision = 32'h0; load_exec = 64'h1; // R9
                @(negedge clk);
                load_valid = 1'b0;
            end
            for (int h = 0; h < hold; h++) @(negedge clk);
            if (hold > 0) check({req, " hold R7"}, lane_mask, exp_m[k]);
            layer_done = 1'b1;
            @(negedge clk);
            layer_done = 1'b0;
        end
        check({req, " idle after final R8"}, 64'(lane_valid), 64'(0));
        for (int w = 0; w < 4; w++) @(negedge clk);
        check({req, " stays idle"}, 64'(lane_valid), 64'(0));
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 valid", 64'(lane_valid), 64'(0));
        check("R1 last", 64'(lane_last), 64'(0));
    endtask

    task automatic test_stray_done();
        layer_done = 1'b1;  // R11: no layer presented
        @(negedge clk); @(negedge clk);
        layer_done = 1'b0;
        check("R11 no valid", 64'(lane_valid), 64'(0));
        run_case("R11 after stray done", 32'h4, 1'b1, '1, 0, 1'b0);
    endtask

    task automatic test_zero_exec();
        do_load(32'h84, 1'b1, 64'h0);
        for (int w = 0; w < 6; w++) @(negedge clk);
        check("R10 no layer", 64'(lane_valid), 64'(0));
        // narrow wave whose active lanes sit only above lane 31
        do_load(32'h0, 1'b0, 64'hFFFF_FFFF_0000_0000);
        for (int w = 0; w < 6; w++) @(negedge clk);
        check("R10 R4 narrow upper-only", 64'(lane_valid), 64'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        // R2 worked example, with holds
        build(32'h0000_0384, 1'b1, '1);
        check("R2 example count", 64'(exp_n), 64'(5));
        check("R2 layer1", exp_m[1], 64'h0000_0000_0FFF_FF00);
        run_case("R2 example", 32'h0000_0384, 1'b1, '1, 2, 1'b0);
        run_case("R3 bit0 set", 32'h0000_0385, 1'b1, '1, 0, 1'b0);
        run_case("R3 single layer", 32'h0, 1'b1, '1, 0, 1'b0);
        run_case("R3 every quad", 32'hFFFF, 1'b1, '1, 0, 1'b0);
        run_case("R4 narrow", 32'hFFFF_0F12, 1'b0, '1, 1, 1'b0);
        run_case("R4 wide high bits", 32'hFFFF_0100, 1'b1, '1, 0, 1'b0);
        run_case("R5 exec sparse", 32'h0000_1224, 1'b1, 64'h8001_0000_0300_1001, 0, 1'b0);
        run_case("R6 skip empty", 32'h0000_00F2, 1'b1, 64'hF000_0000_0000_F00F, 0, 1'b0);
        run_case("R9 busy load", 32'h0000_0110, 1'b1, '1, 1, 1'b1);
        test_stray_done();
        test_zero_exec();
        run_case("R8 after empty load", 32'h0000_0008, 1'b0, 64'h0000_0000_F000_00F0, 0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule